// File: doc/BRIEF.md
# Cascadable Serial Command and Fault Readout Port

This block is the serial slave port of a four-channel low-side gate predriver. A controller frames a transfer with an active-low chip select and a serial clock. When the select drops, the port takes a snapshot of the live per-channel fault vector into its shift register and starts driving its serial output. Fault bits leave first, most significant first. Command bits shifted in on the data input follow them out, so several ports can be chained output-to-input and loaded with one long frame.

When the select rises, the four bits that most recently entered the shift register become the channel command register. The serial output is released and fault capture is armed again. While the select is low, the snapshot is frozen and fault changes are ignored. The serial clock, select, data and fault inputs come from outside the system clock domain. They are synchronised and edge-detected on a fast system clock. The serial output is given as a data bit plus an output enable, with no tri-state pad.

Top module: `predrv_serial_port`

## Requirements
- R1: While rst_n is low, and right after it is released, cmd_q reads 0000 (all channels off), sdo_oe is 0, sdo is 0 and fault_arm is 1.
- R2: On a falling edge of cs_n, sdo_oe goes to 1 and fault_arm goes to 0. The shift register takes the fault_live value, and sdo shows fault_live[3] before any serial clock.
- R3: On each rising sclk edge while cs_n is low, sdi enters the least significant bit of the shift register. sdo changes only on a falling sclk edge, when it takes the new most significant bit, or on a falling cs_n edge.
- R4: The bit stream on sdo is fault bits 3, 2, 1, 0, followed by the sdi bits in the order they were sent. With eight clocks the second group of four is the first four command bits sent.
- R5: On a rising edge of cs_n, cmd_q takes the last four bits shifted in, with the earliest of them in cmd_q[3] and the last in cmd_q[0]. sdo_oe returns to 0 and fault_arm returns to 1.
- R6: If fewer than four sclk rising edges occur in a frame, the unshifted low fault bits stay in the upper bits of cmd_q. For example, fault 0110 followed by two 1 bits gives 1011, and a frame with no clocks gives the fault snapshot itself.
- R7: A change of fault_live while cs_n is low does not change the bits read out in that frame.
- R8: cmd_q changes only on a rising edge of cs_n. Shifting during a frame leaves it unchanged.
- R9: A 1 in cmd_q[i] commands channel i on and a 0 commands it off. Frames with 4, 8 and 12 clocks each commit exactly the last four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select framing a transfer |
| sdi | input | 1 | Serial command data in |
| fault_live | input | NCH (4) | Live per-channel fault flags |
| sdo | output | 1 | Serial data out (fault bits, then passed-through data) |
| sdo_oe | output | 1 | Drive enable for sdo; 0 means released |
| cmd_q | output | NCH (4) | Committed channel on/off commands |
| fault_arm | output | 1 | 1 when the next select fall may capture faults |

## Verification
The hardest situation to reach is a frame whose commit mixes leftover fault bits with command bits. This happens only when the controller stops short of four clocks. The stimulus table includes frames with zero and two clocks to force that case. A second hard case is a fault that changes in mid-frame. A directed test flips fault_live after the select has fallen and then checks that the streamed bits still match the earlier snapshot.

// File: rtl/predrv_pkg.sv
package predrv_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic lvl;
  } edge_t;
endpackage

// File: rtl/predrv_sync.sv
module predrv_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/predrv_edge.sv
module predrv_edge
  import predrv_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig,
  output edge_t ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= sig;
  end

  always_comb begin
    ev.lvl  = sig;
    ev.rise = sig & ~prev_q;
    ev.fall = ~sig & prev_q;
  end
endmodule

// File: rtl/predrv_shift_core.sv
module predrv_shift_core
  import predrv_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  edge_t          cs_ev,
  input  edge_t          sclk_ev,
  input  logic           sdi_s,
  input  logic [NCH-1:0] fault_s,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [NCH-1:0] cmd_q,
  output logic           fault_arm
);
  localparam int MSB = NCH - 1;

  logic [NCH-1:0] shreg_q, shreg_d, cmd_d;
  logic           sdo_q, sdo_d, oe_q, oe_d, arm_q, arm_d;
  logic           upd_en;

  assign upd_en = cs_ev.fall | cs_ev.rise | sclk_ev.rise | sclk_ev.fall;

  always_comb begin
    shreg_d = shreg_q;
    cmd_d   = cmd_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    arm_d   = arm_q;
    if (cs_ev.fall) begin
      shreg_d = fault_s;
      sdo_d   = fault_s[MSB];
      oe_d    = 1'b1;
      arm_d   = 1'b0;
    end else if (cs_ev.rise) begin
      cmd_d = shreg_q;
      oe_d  = 1'b0;
      arm_d = 1'b1;
    end else if (!cs_ev.lvl) begin
      if (sclk_ev.rise) shreg_d = {shreg_q[MSB-1:0], sdi_s};
      if (sclk_ev.fall) sdo_d = shreg_q[MSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cmd_q   <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      arm_q   <= 1'b1;
    end else if (upd_en) begin
      shreg_q <= shreg_d;
      cmd_q   <= cmd_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
      arm_q   <= arm_d;
    end
  end

  assign sdo       = sdo_q;
  assign sdo_oe    = oe_q;
  assign fault_arm = arm_q;
endmodule

// File: rtl/predrv_serial_port.sv
module predrv_serial_port
  import predrv_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           sdi,
  input  logic [NCH-1:0] fault_live,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [NCH-1:0] cmd_q,
  output logic           fault_arm
);
  localparam int SW = NCH + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b0, {NCH{1'b0}}};

  logic [SW-1:0]  raw_in, sync_out;
  logic           cs_s, sclk_s, sdi_s;
  logic [NCH-1:0] fault_s;
  edge_t          cs_ev, sclk_ev;

  assign raw_in = {cs_n, sclk, sdi, fault_live};

  predrv_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign {cs_s, sclk_s, sdi_s, fault_s} = sync_out;

  predrv_edge #(.RST_VAL(1'b1)) cs_edge_i (
    .clk(clk), .rst_n(rst_n), .sig(cs_s), .ev(cs_ev)
  );

  predrv_edge #(.RST_VAL(1'b0)) sclk_edge_i (
    .clk(clk), .rst_n(rst_n), .sig(sclk_s), .ev(sclk_ev)
  );

  predrv_shift_core #(.NCH(NCH)) core_i (
    .clk(clk), .rst_n(rst_n), .cs_ev(cs_ev), .sclk_ev(sclk_ev),
    .sdi_s(sdi_s), .fault_s(fault_s), .sdo(sdo), .sdo_oe(sdo_oe),
    .cmd_q(cmd_q), .fault_arm(fault_arm)
  );
endmodule

// File: rtl/predrv_serial_port_chk.sv
module predrv_serial_port_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_fall,
  input logic           cs_rise,
  input logic           sclk_fall,
  input logic [NCH-1:0] fault_s,
  input logic           sdo,
  input logic           sdo_oe,
  input logic [NCH-1:0] cmd_q,
  input logic           fault_arm
);
  a_r2_open_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && !fault_arm));

  a_r2_first_fault_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo == $past(fault_s[NCH-1])));

  a_r3_sdo_moves_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_fall) |=> $stable(sdo));

  a_r5_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdo_oe && fault_arm));

  a_r8_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cmd_q));

  a_r7_no_arm_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !fault_arm);
endmodule

bind predrv_serial_port predrv_serial_port_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_ev.fall), .cs_rise(cs_ev.rise),
  .sclk_fall(sclk_ev.fall), .fault_s(fault_s), .sdo(sdo), .sdo_oe(sdo_oe),
  .cmd_q(cmd_q), .fault_arm(fault_arm)
);

// File: tb/predrv_serial_port_tb_top.sv
module predrv_serial_port_tb_top;
  logic       clk, rst_n, sclk, cs_n, sdi;
  logic [3:0] fault_live;
  logic       sdo, sdo_oe, fault_arm;
  logic [3:0] cmd_q;
  int         checks, errors;
  bit         done;

  predrv_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .fault_live(fault_live), .sdo(sdo), .sdo_oe(sdo_oe),
    .cmd_q(cmd_q), .fault_arm(fault_arm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: fault[23:20] nclk[19:16] data[15:4] (sent from bit nclk-1 down) exp_cmd[3:0]
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'hA40066, 24'h0400FF, 24'hF80399, 24'h62003B, 24'h900009, 24'h5CC366
  };

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(logic [3:0] act, logic [3:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic sbit(logic [3:0] f, int n, logic [11:0] d, int p);
    if (p < 4) return f[3-p];
    return d[n-1-(p-4)];
  endfunction

  task automatic clk_bit(logic b);
    sdi = b; wt(10);
    sclk = 1'b1; wt(10);
    sclk = 1'b0; wt(10);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; fault_live = 4'h0;
    wt(5);
    chk({1'b0, sdo_oe, sdo, fault_arm}, 4'b0001, "R1 outputs in reset");
    chk(cmd_q, 4'h0, "R1 cmd in reset");
    rst_n = 1'b1; wt(10);
    chk({1'b0, sdo_oe, sdo, fault_arm}, 4'b0001, "R1 outputs after release");
    chk(cmd_q, 4'h0, "R1 cmd after release");

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  f, ec, prev;
      logic [11:0] d;
      int          n;
      f = VEC[v][23:20]; n = int'(VEC[v][19:16]); d = VEC[v][15:4]; ec = VEC[v][3:0];
      prev = cmd_q;
      fault_live = f; wt(10);
      cs_n = 1'b0; wt(10);
      chk({2'b0, sdo_oe, fault_arm}, 4'b0010, "R2 oe up, arm down");
      chk({3'b0, sdo}, {3'b0, f[3]}, "R2 first fault bit");
      for (int k = 0; k < n; k++) begin
        clk_bit(d[n-1-k]);
        chk({3'b0, sdo}, {3'b0, sbit(f, n, d, k+1)}, "R3 R4 stream bit");
        chk(cmd_q, prev, "R8 cmd held in frame");
      end
      cs_n = 1'b1; wt(10);
      chk(cmd_q, ec, (n < 4) ? "R6 short frame commit" : "R5 R9 commit last four");
      chk({2'b0, sdo_oe, fault_arm}, 4'b0001, "R5 release and rearm");
    end

    // R7: fault change inside a frame is ignored
    fault_live = 4'b1100; wt(10);
    cs_n = 1'b0; wt(10);
    fault_live = 4'b0011; wt(10);
    chk({3'b0, sdo}, 4'b0001, "R7 snapshot bit3 kept");
    clk_bit(1'b0); chk({3'b0, sdo}, 4'b0001, "R7 snapshot bit2 kept");
    clk_bit(1'b1); chk({3'b0, sdo}, 4'b0000, "R7 snapshot bit1 kept");
    clk_bit(1'b0); chk({3'b0, sdo}, 4'b0000, "R7 snapshot bit0 kept");
    clk_bit(1'b1); chk({3'b0, sdo}, 4'b0000, "R4 first data bit out");
    cs_n = 1'b1; wt(10);
    chk(cmd_q, 4'b0101, "R9 channels 2 and 0 on");

    // R1: reset in mid-frame clears commands and closes the port
    cs_n = 1'b0; wt(10);
    clk_bit(1'b1);
    rst_n = 1'b0; wt(3);
    chk(cmd_q, 4'h0, "R1 reset mid-frame cmd");
    chk({2'b0, sdo_oe, fault_arm}, 4'b0001, "R1 reset mid-frame flags");
    cs_n = 1'b1; rst_n = 1'b1; wt(10);
    chk(cmd_q, 4'h0, "R1 cmd stays off");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule